// File: doc/BRIEF.md
# Keyed Software Reset Line Controller

This block holds a bank of individual reset lines for peripherals. Each line is one bit of a single 32-bit register in a small register window. Software sets a bit to hold the matching peripheral in reset and clears it to release the peripheral. To change one line without touching the others, software reads the register, edits the bit and writes the whole word back. A full reset pulse on one line is two such writes: one that sets the bit and one that clears it again.

Stray writes could reset peripherals by mistake, so the register only accepts a write whose most significant byte carries an unlock code. The code is never stored. It and every bit above the last implemented line read back as zero. The number of lines is a parameter, from 1 to 24, because the unlock byte takes the top eight bits of the word.

The register interface has single-cycle write and read strobes. Read data is combinational on the current address. Reset line outputs come straight from flops.

Top module: `keyed_rst_bank`

## Requirements
- R1: A synchronous active-high `rst` clears every reset line to 0, and this overrides any write in the same cycle.
- R2: The write is accepted when all three conditions hold:
  - `bus_wr` is 1;
  - `bus_addr` equals the bank offset 0x18;
  - `bus_wdata[31:24]` equals 0x88.
  
  On the clock edge of an accepted write, `rst_lines` takes `bus_wdata[NUM_LINES-1:0]`. Bit i drives line i, and 1 means the line is asserted.
- R3: A write to offset 0x18 whose top byte is not 0x88 leaves `rst_lines` unchanged.
- R4: A write to any address other than 0x18 leaves `rst_lines` unchanged, even when it carries the 0x88 key.
- R5: While `bus_rd` is 1 and `bus_addr` is 0x18, `bus_rdata` shows:
  - bit i equal to line i for i below NUM_LINES;
  - 0 in every other bit, including the key byte.
- R6: `bus_rdata` is 0 whenever `bus_rd` is 0 or `bus_addr` is not 0x18.
- R7: Write data bits from NUM_LINES to 23 are not stored and do not change any output.
- R8: When a read and an accepted write happen in the same cycle, the read returns the bank value from before the write.
- R9: A read-modify-write that sets and then clears one bit gives a one-write-long pulse on that line only. All other lines keep their values.
- R10: While `bus_wr` is 0, `rst_lines` does not change, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | 32 | Write data: key in [31:24], line bits below |
| bus_rdata | output | 32 | Read data, zero unless the bank is read |
| rst_lines | output | NUM_LINES | Reset line outputs, 1 = asserted |

## Verification
A read of the bank and an accepted write to it can land in the same cycle. The bench provokes this by raising both strobes at offset 0x18 with a valid key and a value that differs from the stored one. It then checks two things: the read data in that cycle equals the old bank value, and the new value appears on the lines after the edge. The same collision occurs within the read-modify-write pulse sequence, and a behavioural model checks every cycle of that sequence. Wrong-key, wrong-address and strobe-low writes are placed between keyed writes, so any leakage would show on the lines.

// File: rtl/rstbank_pkg.sv
package rstbank_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned CODE_W    = 8;
    localparam int unsigned PAYLOAD_W = WORD_W - CODE_W;
    localparam logic [CODE_W-1:0] UNLOCK_CODE = 8'h88;

    typedef struct packed {
        logic [CODE_W-1:0]    code;
        logic [PAYLOAD_W-1:0] payload;
    } bank_word_t;

    typedef struct packed {
        logic sel_wr;
        logic sel_rd;
        logic code_ok;
    } access_t;

    function automatic logic code_matches(input logic [CODE_W-1:0] code);
        return code == UNLOCK_CODE;
    endfunction

    function automatic logic commit_ok(input access_t acc);
        return acc.sel_wr && acc.code_ok;
    endfunction

endpackage

// File: rtl/rstbank_decode.sv
module rstbank_decode
    import rstbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 'h18
) (
    input  logic                 wr,
    input  logic                 rd,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    output access_t              acc,
    output logic [PAYLOAD_W-1:0] payload
);
    bank_word_t word;
    logic       hit;

    always_comb begin
        word        = bank_word_t'(wdata);
        hit         = (addr == BANK_ADDR);
        acc.sel_wr  = wr && hit;
        acc.sel_rd  = rd && hit;
        acc.code_ok = code_matches(word.code);
        payload     = word.payload;
    end
endmodule

// File: rtl/rstbank_store.sv
module rstbank_store #(
    parameter int unsigned NUM_LINES = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 commit,
    input  logic [NUM_LINES-1:0] next_bits,
    output logic [NUM_LINES-1:0] bits
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                bits[i] <= 1'b0;
            end else if (commit) begin
                bits[i] <= next_bits[i];
            end
        end
    end
endmodule

// File: rtl/rstbank_readback.sv
module rstbank_readback
    import rstbank_pkg::*;
#(
    parameter int unsigned NUM_LINES = 20
) (
    input  logic                 sel,
    input  logic [NUM_LINES-1:0] bits,
    output logic [WORD_W-1:0]    rdata
);
    localparam int unsigned PAD_W = WORD_W - NUM_LINES;

    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata = {{PAD_W{1'b0}}, bits};
        end
    end
endmodule

// File: rtl/keyed_rst_bank.sv
module keyed_rst_bank
    import rstbank_pkg::*;
#(
    parameter int unsigned NUM_LINES = 20,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 'h18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] rst_lines
);
    access_t              acc;
    logic [PAYLOAD_W-1:0] payload;
    logic                 commit;

    rstbank_decode #(
        .ADDR_W   (ADDR_W),
        .BANK_ADDR(BANK_ADDR)
    ) u_decode (
        .wr     (bus_wr),
        .rd     (bus_rd),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .acc    (acc),
        .payload(payload)
    );

    assign commit = commit_ok(acc);

    rstbank_store #(
        .NUM_LINES(NUM_LINES)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .next_bits(payload[NUM_LINES-1:0]),
        .bits     (rst_lines)
    );

    rstbank_readback #(
        .NUM_LINES(NUM_LINES)
    ) u_readback (
        .sel  (acc.sel_rd),
        .bits (rst_lines),
        .rdata(bus_rdata)
    );
endmodule

// File: rtl/rstbank_chk.sv
module rstbank_chk #(
    parameter int unsigned NUM_LINES = 20,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 'h18
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] rst_lines
);
    logic hit;
    assign hit = (bus_addr == BANK_ADDR);

    a_r2_keyed_update: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit && bus_wdata[31:24] == 8'h88)
        |=> rst_lines == $past(bus_wdata[NUM_LINES-1:0]));

    a_r3_bad_key_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit && bus_wdata[31:24] != 8'h88) |=> $stable(rst_lines));

    a_r4_other_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !hit) |=> $stable(rst_lines));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(rst_lines));

    a_r5_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit) |-> bus_rdata == {{(32-NUM_LINES){1'b0}}, rst_lines});

    a_r6_quiet_read: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && hit) |-> bus_rdata == 32'h0);
endmodule

bind keyed_rst_bank rstbank_chk #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W),
    .BANK_ADDR(BANK_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .rst_lines(rst_lines)
);

// File: tb/keyed_rst_bank_tb.sv
module keyed_rst_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [LINES-1:0] rst_lines;

    int checks = 0;
    int errors = 0;
    logic [LINES-1:0] m_bank = '0;
    logic [31:0] rd_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_rst_bank #(.NUM_LINES(LINES), .ADDR_W(8), .BANK_ADDR(8'h18)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_lines(rst_lines)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check read data, clock, check lines.
    task automatic step(input logic wr, input logic rd, input logic [7:0] addr,
                        input logic [31:0] wd, input string tag);
        logic [31:0] exp_rd;
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd;
        #1;
        exp_rd = (rd && addr == 8'h18) ? {12'h0, m_bank} : 32'h0;
        rd_word = bus_rdata;
        check32({tag, " rdata"}, bus_rdata, exp_rd);
        @(posedge clk);
        if (rst) m_bank = '0;
        else if (wr && addr == 8'h18 && wd[31:24] == 8'h88) m_bank = wd[LINES-1:0];
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check32({tag, " lines"}, {12'h0, rst_lines}, {12'h0, m_bank});
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        step(1'b1, 1'b0, 8'h18, 32'h8800_FFFF, "R1 write under reset");
        step(1'b0, 1'b1, 8'h18, 32'h0, "R1 reset read");
        rst = 1'b0;
        step(1'b0, 1'b1, 8'h18, 32'h0, "R1 after reset");
        check32("R1 lines zero", {12'h0, rst_lines}, 32'h0);

        step(1'b1, 1'b0, 8'h18, 32'h8800_A5A5, "R2 keyed write");
        check32("R2 value", {12'h0, rst_lines}, 32'h0000_A5A5);
        step(1'b0, 1'b1, 8'h18, 32'h0, "R5 readback");
        check32("R5 word", rd_word, 32'h0000_A5A5);

        step(1'b1, 1'b0, 8'h18, 32'h8700_FFFF, "R3 key 0x87");
        step(1'b1, 1'b0, 8'h18, 32'h0000_1234, "R3 key 0x00");
        step(1'b1, 1'b0, 8'h18, 32'h8900_0F0F, "R3 key 0x89");
        check32("R3 unchanged", {12'h0, rst_lines}, 32'h0000_A5A5);

        step(1'b1, 1'b0, 8'h14, 32'h8800_0001, "R4 addr 0x14");
        step(1'b1, 1'b0, 8'h1C, 32'h8800_0002, "R4 addr 0x1C");
        check32("R4 unchanged", {12'h0, rst_lines}, 32'h0000_A5A5);

        step(1'b0, 1'b0, 8'h18, 32'h8800_0003, "R10 strobe low");
        check32("R10 unchanged", {12'h0, rst_lines}, 32'h0000_A5A5);

        step(1'b1, 1'b0, 8'h18, 32'h88F0_0001, "R7 high payload bits");
        check32("R7 lines", {12'h0, rst_lines}, 32'h0000_0001);
        step(1'b0, 1'b1, 8'h18, 32'h0, "R7 readback");
        check32("R7 word", rd_word, 32'h0000_0001);

        step(1'b0, 1'b1, 8'h14, 32'h0, "R6 other addr read");
        check32("R6 zero", rd_word, 32'h0);
        step(1'b0, 1'b0, 8'h18, 32'h0, "R6 no strobe");

        step(1'b1, 1'b1, 8'h18, 32'h8808_0000, "R8 read with write");
        check32("R8 old value", rd_word, 32'h0000_0001);
        check32("R8 new lines", {12'h0, rst_lines}, 32'h0008_0000);

        step(1'b1, 1'b0, 8'h18, 32'h8803_0C30, "R9 setup");
        step(1'b0, 1'b1, 8'h18, 32'h0, "R9 read");
        step(1'b1, 1'b1, 8'h18, 32'h8800_0000 | rd_word | 32'h80, "R9 set line 7");
        check32("R9 pulse high", {12'h0, rst_lines}, 32'h0003_0CB0);
        step(1'b0, 1'b1, 8'h18, 32'h0, "R9 read again");
        step(1'b1, 1'b0, 8'h18, 32'h8800_0000 | (rd_word & ~32'h80), "R9 clear line 7");
        check32("R9 pulse low", {12'h0, rst_lines}, 32'h0003_0C30);

        step(1'b1, 1'b0, 8'h18, 32'h880F_FFFF, "R2 all lines");
        step(1'b0, 1'b1, 8'h18, 32'h0, "R5 all lines read");
        check32("R5 key byte zero", rd_word, 32'h000F_FFFF);
        step(1'b1, 1'b0, 8'h18, 32'h8800_0000, "R2 clear all");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule